// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is a synthesizable register-to-register static memory with a 36-bit word. The word is split into four 9-bit byte lanes. Every control input is captured on the rising clock edge: the active-low chip select, the active-low write enable, four active-low lane write selects and the address. A read places its word in an output register, so the data appears in the cycle after the command. A write takes its address and lane selects in one cycle and its data in the next cycle (late write). The address and lanes are held in a staging register until the next write command commits them to the array.

A read can target the address of a write that has not yet been committed. In that case an address comparator substitutes the staged data in the lanes that write selected. The data bus is split into `din`, `dout` and a drive flag `dout_oe`. An asynchronous active-low output enable gates the drive flag, and so does an asynchronous sleep input. While sleep is high every clocked input is ignored. The depth is set by the address width.

Top module: `lwsram_core`

## Requirements
- R1: After reset is released, `dout_oe` is low.
- R2: A read command is `sel_n`=0, `we_n`=1 and at least one `bwe_n` bit low. One cycle after that edge, `dout` holds the stored word and `dout_oe` is high, provided `oe_n` and `sleep` are low.
- R3: A write command is `sel_n`=0 and `we_n`=0. Lane i is bits [9i+8:9i]. The lane is written only when `bwe_n[i]`=0, and every other lane keeps its content. Any combination of the four lane selects is legal.
- R4: Write data is taken from `din` at the edge after the write command's edge. The value on `din` at the command edge has no effect.
- R5: A read of the address of the latest write returns that write's data in its selected lanes and the array content in the other lanes. This holds even when the write's data arrives on the same edge as the read.
- R6: A cycle with `sel_n`=1 is a dead cycle. In the following cycle `dout_oe` is low.
- R7: A cycle with `sel_n`=0, `we_n`=1 and `bwe_n`=4'b1111 is a dummy read. In the following cycle `dout_oe` is low, and no stored word changes.
- R8: While `oe_n` is high, `dout_oe` is low at once, without waiting for a clock edge.
- R9: While `sleep` is high, `dout_oe` is low at once and every clocked input is ignored. A write issued during sleep does not change memory.
- R10: Back-to-back write commands each store their own data. The staged write is committed when the next write command arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| bwe_n | input | LANES | Per-lane write select, active low |
| addr | input | ADDR_W | Word address |
| din | input | LANES*LANE_W | Write data, sampled one edge after its command |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous power-down, active high |
| dout | output | LANES*LANE_W | Read data from the output register |
| dout_oe | output | 1 | High when the block drives the data bus |

## Verification
The clocked properties assume that `sleep` and `oe_n` only change well away from the rising edge. They also assume that sleep is never entered while a write is still waiting for its data, so the write never loses its data edge. The random stimulus keeps `sleep` and `oe_n` low. Only the directed cases move them, at the falling edge, and only after a cycle that was not a write. Every address is written once before the random phase, so every read has a defined expected value. The random addresses favour a small group so that reads often hit the staged write.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/lwsram_decode.sv
module lwsram_decode
  import lwsram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             sel_n,
  input  logic             we_n,
  input  logic [LANES-1:0] bwe_n,
  input  logic             sleep,
  output op_e              op,
  output logic [LANES-1:0] lane_mask
);
  always_comb begin
    lane_mask = ~bwe_n;
    op        = OP_IDLE;
    if (!sleep && !sel_n) begin
      if (!we_n)               op = OP_WRITE;
      else if (|lane_mask)     op = OP_READ;
      else                     op = OP_IDLE;
    end
  end
endmodule

// File: rtl/lwsram_array.sv
module lwsram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [LANES-1:0]          wr_mask,
  input  logic [LANES*LANE_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [LANES*LANE_W-1:0]   rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic              lane_we;

    assign lane_we = wr_en && wr_mask[g];

    always_ff @(posedge clk) begin
      if (lane_we) mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end

    assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
  end
endmodule

// File: rtl/lwsram_stage.sv
module lwsram_stage
  import lwsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      awake,
  input  op_e                       op,
  input  logic [ADDR_W-1:0]         cmd_addr,
  input  logic [LANES-1:0]          cmd_mask,
  input  logic [LANES*LANE_W-1:0]   din,
  output logic                      commit_en,
  output logic [ADDR_W-1:0]         commit_addr,
  output logic [LANES-1:0]          commit_mask,
  output logic [LANES*LANE_W-1:0]   commit_data,
  output logic [LANES-1:0]          fwd_lanes,
  output logic [LANES*LANE_W-1:0]   fwd_data
);
  localparam int DATA_W = LANES * LANE_W;

  logic              pv_q, pv_d;
  logic              due_q, due_d;
  logic [ADDR_W-1:0] pa_q, pa_d;
  logic [LANES-1:0]  pm_q, pm_d;
  logic [DATA_W-1:0] pd_q, pd_d;
  logic [DATA_W-1:0] cur_data;
  logic              addr_hit;

  // Data of the staged write: still on the bus if its edge is now.
  assign cur_data    = due_q ? din : pd_q;
  assign commit_en   = (op == OP_WRITE) && pv_q;
  assign commit_addr = pa_q;
  assign commit_mask = pm_q;
  assign commit_data = cur_data;
  assign addr_hit    = pv_q && (pa_q == cmd_addr);
  assign fwd_lanes   = addr_hit ? pm_q : '0;
  assign fwd_data    = cur_data;

  always_comb begin
    pv_d  = pv_q;
    due_d = due_q;
    pa_d  = pa_q;
    pm_d  = pm_q;
    pd_d  = pd_q;
    if (op == OP_WRITE) begin
      pv_d  = 1'b1;
      due_d = 1'b1;
      pa_d  = cmd_addr;
      pm_d  = cmd_mask;
    end else if (awake && due_q) begin
      due_d = 1'b0;
      pd_d  = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q  <= 1'b0;
      due_q <= 1'b0;
      pa_q  <= '0;
      pm_q  <= '0;
      pd_q  <= '0;
    end else begin
      pv_q  <= pv_d;
      due_q <= due_d;
      pa_q  <= pa_d;
      pm_q  <= pm_d;
      pd_q  <= pd_d;
    end
  end

  // R4: the data edge follows the command edge
  p_late_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WRITE) ##1 (op != OP_WRITE && awake) |=> (pd_q == $past(din)));

  // R10: a second write commits the first one at the prior address
  p_commit_chain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WRITE) ##1 (op == OP_WRITE) |-> (commit_en && commit_addr == $past(cmd_addr)));
endmodule

// File: rtl/lwsram_core.sv
module lwsram_core
  import lwsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sel_n,
  input  logic                     we_n,
  input  logic [LANES-1:0]         bwe_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [LANES*LANE_W-1:0]  din,
  input  logic                     oe_n,
  input  logic                     sleep,
  output logic [LANES*LANE_W-1:0]  dout,
  output logic                     dout_oe
);
  localparam int DATA_W = LANES * LANE_W;

  logic              rs1_q, rs2_q, rst_i_n;
  op_e               op;
  logic [LANES-1:0]  lane_mask;
  logic              commit_en;
  logic [ADDR_W-1:0] commit_addr;
  logic [LANES-1:0]  commit_mask;
  logic [DATA_W-1:0] commit_data;
  logic [LANES-1:0]  fwd_lanes;
  logic [DATA_W-1:0] fwd_data;
  logic [DATA_W-1:0] arr_data;
  logic [DATA_W-1:0] merged;
  logic              rdv_q, rdv_d;
  logic [DATA_W-1:0] dq_q, dq_d;

  // Reset: asserted at once, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_i_n = rs2_q;

  lwsram_decode #(.LANES(LANES)) u_decode (
    .sel_n(sel_n), .we_n(we_n), .bwe_n(bwe_n), .sleep(sleep),
    .op(op), .lane_mask(lane_mask)
  );

  lwsram_stage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_stage (
    .clk(clk), .rst_n(rst_i_n), .awake(!sleep), .op(op),
    .cmd_addr(addr), .cmd_mask(lane_mask), .din(din),
    .commit_en(commit_en), .commit_addr(commit_addr),
    .commit_mask(commit_mask), .commit_data(commit_data),
    .fwd_lanes(fwd_lanes), .fwd_data(fwd_data)
  );

  lwsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .wr_en(commit_en), .wr_addr(commit_addr),
    .wr_mask(commit_mask), .wr_data(commit_data),
    .rd_addr(addr), .rd_data(arr_data)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign merged[g*LANE_W +: LANE_W] = fwd_lanes[g] ? fwd_data[g*LANE_W +: LANE_W]
                                                     : arr_data[g*LANE_W +: LANE_W];
  end

  always_comb begin
    rdv_d = (op == OP_READ);
    dq_d  = (op == OP_READ) ? merged : dq_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rdv_q <= 1'b0;
      dq_q  <= '0;
    end else begin
      rdv_q <= rdv_d;
      dq_q  <= dq_d;
    end
  end

  assign dout    = dq_q;
  assign dout_oe = rdv_q && !oe_n && !sleep;

  // R6: dead cycle leaves the bus undriven
  p_dead_hiz_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!sleep && sel_n) |=> !dout_oe);

  // R7: dummy read leaves the bus undriven
  p_dummy_hiz_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!sleep && !sel_n && we_n && (&bwe_n)) |=> !dout_oe);

  // R2: a read drives the bus unless gated asynchronously
  p_read_drive_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!sleep && !sel_n && we_n && !(&bwe_n)) |=> (sleep || oe_n || dout_oe));

  // R3: a write cycle never drives the bus next
  p_write_hiz_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!sleep && !sel_n && !we_n) |=> !dout_oe);
endmodule

// File: tb/lwsram_core_tb.sv
module lwsram_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 36;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sel_n, we_n, oe_n, sleep;
  logic [3:0]    bwe_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          dout_oe;

  int n_run = 0;
  int n_fail = 0;

  logic [DW-1:0] mdl [DEPTH];
  logic          due;
  logic [AW-1:0] pend_a;
  logic [3:0]    pend_m;
  logic          exp_oe;
  logic [DW-1:0] exp_q;
  logic [AW-1:0] last_wa;

  always #(CLK_PERIOD/2) clk = ~clk;

  lwsram_core #(.ADDR_W(AW), .LANES(4), .LANE_W(9)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .we_n(we_n), .bwe_n(bwe_n),
    .addr(addr), .din(din), .oe_n(oe_n), .sleep(sleep),
    .dout(dout), .dout_oe(dout_oe)
  );

  function automatic logic [DW-1:0] lane_merge(logic [DW-1:0] old_w, logic [DW-1:0] new_w,
                                               logic [3:0] wmask);
    logic [DW-1:0] r = old_w;
    for (int i = 0; i < 4; i++)
      if (wmask[i]) r[i*9 +: 9] = new_w[i*9 +: 9];
    return r;
  endfunction

  function automatic logic [DW-1:0] rnd36();
    logic [31:0] hi = $urandom();
    logic [31:0] lo = $urandom();
    return {hi[3:0], lo};
  endfunction

  task automatic check(input logic ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, expv, $time);
    end
  endtask

  // One clock: drive now (after a falling edge), update the model at the
  // rising edge, compare at the next falling edge.
  task automatic step(input logic s_n, input logic w_n, input logic [3:0] b_n,
                      input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic slp, input string tag);
    logic rd, wr;
    sel_n = s_n; we_n = w_n; bwe_n = b_n; addr = a; din = d; sleep = slp;
    rd = !slp && !s_n && w_n && (b_n != 4'hF);
    wr = !slp && !s_n && !w_n;
    @(posedge clk);
    if (!slp) begin
      if (due) begin
        mdl[pend_a] = lane_merge(mdl[pend_a], d, pend_m);
        due = 1'b0;
      end
      if (rd) exp_q = mdl[a];
      if (wr) begin
        due = 1'b1; pend_a = a; pend_m = ~b_n; last_wa = a;
      end
    end
    exp_oe = rd;
    @(negedge clk);
    check(dout_oe === exp_oe, tag, {35'd0, dout_oe}, {35'd0, exp_oe});
    if (exp_oe) check(dout === exp_q, tag, dout, exp_q);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    logic [DW-1:0] old9;
    void'($urandom(32'd20240607));
    due = 1'b0; pend_a = '0; pend_m = '0; last_wa = '0; exp_q = '0;
    rst_n = 1'b0; sel_n = 1'b1; we_n = 1'b1; bwe_n = 4'hF; addr = '0;
    din = '0; oe_n = 1'b0; sleep = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(dout_oe === 1'b0, "R1", {35'd0, dout_oe}, '0);

    // R10: fill with back-to-back writes, data of each in the next step
    for (int i = 0; i < DEPTH; i++) begin
      d = (i == 0) ? '0 : {18'h2AB00 | 18'(i - 1), 18'(i - 1) ^ 18'h15555};
      step(1'b0, 1'b0, 4'h0, AW'(i), d, 1'b0, "R10");
    end
    step(1'b1, 1'b1, 4'hF, '0, {18'h2AB00 | 18'(DEPTH - 1), 18'(DEPTH - 1) ^ 18'h15555},
         1'b0, "R6");
    for (int i = 0; i < 8; i++)
      step(1'b0, 1'b1, 4'h0, AW'(i * 7), rnd36(), 1'b0, "R10");

    // R4: bus value at the command edge is not the data
    step(1'b0, 1'b0, 4'h0, AW'(5), 36'h0AAAAAAAA, 1'b0, "R4");
    step(1'b1, 1'b1, 4'hF, '0, 36'h123456789, 1'b0, "R4");
    step(1'b0, 1'b1, 4'h0, AW'(5), rnd36(), 1'b0, "R4");
    check(dout === 36'h123456789, "R4", dout, 36'h123456789);

    // R5 / R3: partial write, read on the data edge, then again
    step(1'b0, 1'b0, 4'b1010, AW'(7), rnd36(), 1'b0, "R3");
    step(1'b0, 1'b1, 4'h0, AW'(7), 36'hFEDCBA987, 1'b0, "R5");
    step(1'b0, 1'b1, 4'h0, AW'(7), rnd36(), 1'b0, "R5");
    step(1'b0, 1'b0, 4'h0, AW'(8), rnd36(), 1'b0, "R10");
    step(1'b0, 1'b1, 4'h1, AW'(7), rnd36(), 1'b0, "R3");

    // R7: dummy read on address 9 changes nothing
    step(1'b0, 1'b1, 4'hF, AW'(9), rnd36(), 1'b0, "R7");
    step(1'b0, 1'b1, 4'h0, AW'(9), rnd36(), 1'b0, "R7");

    // R8: output enable gates without a clock
    oe_n = 1'b1; #1;
    check(dout_oe === 1'b0, "R8", {35'd0, dout_oe}, '0);
    oe_n = 1'b0; #1;
    check(dout_oe === 1'b1 && dout === mdl[9], "R8", dout, mdl[9]);

    // R9: sleep gates at once and blocks a write
    old9 = mdl[9];
    sleep = 1'b1; #1;
    check(dout_oe === 1'b0, "R9", {35'd0, dout_oe}, '0);
    step(1'b0, 1'b0, 4'h0, AW'(9), rnd36(), 1'b1, "R9");
    step(1'b1, 1'b1, 4'hF, '0, 36'h0DEADBEEF, 1'b1, "R9");
    step(1'b0, 1'b1, 4'h0, AW'(9), rnd36(), 1'b0, "R9");
    check(dout === old9, "R9", dout, old9);

    // Random traffic
    for (int k = 0; k < 4000; k++) begin
      int unsigned op = $urandom() % 8;
      logic [AW-1:0] a = ($urandom() % 2 == 0) ? AW'($urandom() % 8) : AW'($urandom());
      logic [3:0] b = 4'($urandom());
      d = rnd36();
      if (op < 4) begin
        if (b == 4'hF) b = 4'h0;
        step(1'b0, 1'b1, b, a, d, 1'b0, (a == last_wa) ? "R5" : "R2");
      end else if (op < 6) begin
        step(1'b0, 1'b0, b, a, d, 1'b0, "R3");
      end else if (op == 6) begin
        step(1'b1, 1'($urandom()), b, a, d, 1'b0, "R6");
      end else begin
        step(1'b0, 1'b1, 4'hF, a, d, 1'b0, "R7");
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule